// File: doc/BRIEF.md
# CAN Bit Timing Generator

This block turns the module clock into time quanta and steps every nominal CAN bit through four segments in a fixed order: synchronization, propagation, phase 1 and phase 2. It sends frame-level logic three one-clock strobes. One marks the start of each bit, where the transmitter may change the bus level. One marks the sample point, where the receiver takes the bus value. One marks the natural end of a bit.

The quantum length comes from a prescaler. Each segment length is a count of quanta. With these settings, nodes running from different oscillators can reach the same bit rate, up to 1 Mbit/s. The block takes a synchronized receive line and an idle indication from the frame logic. When the bus is idle, a recessive-to-dominant edge restarts the bit. During a frame, an edge moves the sample point. Phase 1 is stretched or phase 2 is cut by the measured phase error, and the change is never larger than the jump width. The block also checks the configuration. An illegal setting raises a flag and stops all strobes.

Top module: `can_bit_timer`

## Requirements
- R1: One quantum lasts 2*(prescale+1) clock cycles. With no receive edges, consecutive bit-start strobes are (1+prop_len+ph1_len+ph2_len) quanta apart. The synchronization segment is always one quantum long.
- R2: The sample strobe comes (1+prop_len+ph1_len) quanta after the bit-start strobe, at the end of phase 1. The sample strobe and the bit-start strobe never occur in the same cycle.
- R3: Each strobe lasts one clock cycle. bit_end rises in the same cycle as tx_pulse whenever phase 2 runs to its end.
- R4: cfg_bad is 1 when any of these holds: prop_len, ph1_len or sjw is 0; ph2_len is below 2; ph2_len is below sjw; the total bit length 1+prop_len+ph1_len+ph2_len is below 8 or above 25 quanta.
- R5: While cfg_bad is 1, no strobe is produced.
- R6: A falling rx edge (1 to 0) while bus_idle is 1 is a hard synchronization. It raises tx_pulse two clock cycles after rx falls, without bit_end. It restarts quantum timing, so the sample strobe follows the hard-sync strobe after the normal (1+prop_len+ph1_len) quanta.
- R7: A falling rx edge during the propagation segment or phase 1, with bus_idle at 0, lengthens phase 1 by min(e, sjw). Here e is the number of quanta from the end of the synchronization segment up to and including the quantum in which the edge is seen.
- R8: A falling rx edge during phase 2, with bus_idle at 0, shortens phase 2 by min(r, sjw). Here r is the number of whole phase-2 quanta that remain after the quantum in which the edge is seen.
- R9: At most one resynchronization takes place per bit. A falling edge inside the synchronization segment and any rising rx edge have no effect on timing.
- R10: While rst is 1, and in the cycle after it, every output is 0.
- R11: An edge seen in the same cycle as the quantum tick that would end phase 1 still lengthens phase 1 by the clamped error, and the sample strobe is delayed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| prescale | input | PRE_W | Quantum length select; quantum = 2*(prescale+1) clocks |
| prop_len | input | SEG_W | Propagation segment length in quanta |
| ph1_len | input | SEG_W | Phase 1 length in quanta |
| ph2_len | input | SEG_W | Phase 2 length in quanta |
| sjw | input | SJW_W | Synchronization jump width in quanta |
| bus_idle | input | 1 | 1 when the frame logic considers the bus idle (selects hard sync) |
| rx | input | 1 | Synchronized receive line, 1 = recessive |
| tx_pulse | output | 1 | One-cycle strobe at the start of each bit |
| sample_pulse | output | 1 | One-cycle strobe at the sample point |
| bit_end | output | 1 | One-cycle strobe when a bit completes phase 2 |
| cfg_bad | output | 1 | Configuration is illegal; strobes are held off |

## Verification
A resynchronizing edge can arrive in the same clock cycle as the quantum tick that would otherwise close phase 1. In that cycle the sequencer must settle the extension and the segment-end decision together. The bench provokes this by lowering rx at the exact negedge that puts the registered edge on the phase-1 closing tick. It then checks that the sample strobe moves out by the full jump width rather than firing at the nominal point. A second overlap also gets a directed case: a hard-sync edge lands a few cycles after a sample strobe and preempts the phase-2 quantum ticks that would otherwise run. The bench checks that the new bit strobe appears without bit_end and that the next sample keeps nominal spacing.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PROP = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/cbt_quantum_div.sv
// Divides the module clock into quanta of 2*(prescale+1) cycles.
module cbt_quantum_div #(
  parameter int PRE_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             restart,
  input  logic [PRE_W-1:0] prescale,
  output logic             tq_tick
);
  localparam int CW = PRE_W + 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim     = {prescale, 1'b1};
  assign tq_tick = !hold && !restart && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst || hold || restart) begin
      cnt <= '0;
    end else if (cnt >= lim) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/cbt_cfg_check.sv
// Flags segment settings that cannot form a legal bit.
module cbt_cfg_check #(
  parameter int SEG_W  = 4,
  parameter int SJW_W  = 3,
  parameter int MIN_TQ = 8,
  parameter int MAX_TQ = 25
) (
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic [SJW_W-1:0] sjw,
  output logic             bad
);
  localparam int TW = SEG_W + 3;
  localparam logic [TW-1:0] T_MIN = TW'(MIN_TQ);
  localparam logic [TW-1:0] T_MAX = TW'(MAX_TQ);

  logic [TW-1:0] total;
  logic          zero_len;
  logic          ph2_short;
  logic          len_out;

  always_comb begin
    total     = TW'(1) + TW'(prop_len) + TW'(ph1_len) + TW'(ph2_len);
    zero_len  = (prop_len == '0) || (ph1_len == '0) || (sjw == '0);
    ph2_short = (TW'(ph2_len) < TW'(2)) || (TW'(ph2_len) < TW'(sjw));
    len_out   = (total < T_MIN) || (total > T_MAX);
    bad       = zero_len || ph2_short || len_out;
  end
endmodule

// File: rtl/cbt_edge_det.sv
// Registers the receive line and flags recessive-to-dominant transitions.
module cbt_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic rx,
  output logic fall
);
  logic rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= 1'b1;
      fall <= 1'b0;
    end else begin
      rx_q <= rx;
      fall <= rx_q & ~rx;
    end
  end
endmodule

// File: rtl/cbt_seg_seq.sv
// Steps through the four segments, applies hard sync and resynchronization.
module cbt_seg_seq
  import cbt_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic             tq_tick,
  input  logic             fall,
  input  logic             bus_idle,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic [SJW_W-1:0] sjw,
  output logic             restart,
  output logic             tx_pulse,
  output logic             sample_pulse,
  output logic             bit_end
);
  localparam int QW = SEG_W + 2;
  localparam logic [QW-1:0] ONE = QW'(1);

  seg_e             seg;
  logic [QW-1:0]    qcnt;
  logic [SJW_W-1:0] ext, ext_n;
  logic [SJW_W-1:0] shrt, shrt_n;
  logic             resynced;
  logic             took;
  logic             resync_ok;
  logic [QW-1:0]    err;
  logic [QW-1:0]    rem;
  logic             prop_end, ph1_end, ph2_end;

  assign restart   = fall && bus_idle && !hold;
  assign resync_ok = fall && !bus_idle && !resynced && !hold;

  always_comb begin
    ext_n  = ext;
    shrt_n = shrt;
    took   = 1'b0;
    err    = (seg == SEG_PROP) ? (qcnt + ONE) : (QW'(prop_len) + qcnt + ONE);
    rem    = QW'(ph2_len) - qcnt - ONE;
    if (resync_ok) begin
      case (seg)
        SEG_PROP, SEG_PH1: begin
          ext_n = (err > QW'(sjw)) ? sjw : err[SJW_W-1:0];
          took  = 1'b1;
        end
        SEG_PH2: begin
          shrt_n = (rem > QW'(sjw)) ? sjw : rem[SJW_W-1:0];
          took   = 1'b1;
        end
        default: ;
      endcase
    end
    prop_end = (qcnt + ONE) >= QW'(prop_len);
    ph1_end  = (qcnt + ONE) >= (QW'(ph1_len) + QW'(ext_n));
    ph2_end  = (qcnt + ONE) >= (QW'(ph2_len) - QW'(shrt_n));
  end

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      seg          <= SEG_SYNC;
      qcnt         <= '0;
      ext          <= '0;
      shrt         <= '0;
      resynced     <= 1'b0;
      tx_pulse     <= 1'b0;
      sample_pulse <= 1'b0;
      bit_end      <= 1'b0;
    end else begin
      tx_pulse     <= 1'b0;
      sample_pulse <= 1'b0;
      bit_end      <= 1'b0;
      if (restart) begin
        seg      <= SEG_SYNC;
        qcnt     <= '0;
        ext      <= '0;
        shrt     <= '0;
        resynced <= 1'b1;
        tx_pulse <= 1'b1;
      end else begin
        ext  <= ext_n;
        shrt <= shrt_n;
        if (took) resynced <= 1'b1;
        if (tq_tick) begin
          case (seg)
            SEG_SYNC: begin
              seg  <= SEG_PROP;
              qcnt <= '0;
            end
            SEG_PROP: begin
              if (prop_end) begin
                seg  <= SEG_PH1;
                qcnt <= '0;
              end else begin
                qcnt <= qcnt + ONE;
              end
            end
            SEG_PH1: begin
              if (ph1_end) begin
                seg          <= SEG_PH2;
                qcnt         <= '0;
                sample_pulse <= 1'b1;
              end else begin
                qcnt <= qcnt + ONE;
              end
            end
            default: begin
              if (ph2_end) begin
                seg      <= SEG_SYNC;
                qcnt     <= '0;
                ext      <= '0;
                shrt     <= '0;
                resynced <= 1'b0;
                tx_pulse <= 1'b1;
                bit_end  <= 1'b1;
              end else begin
                qcnt <= qcnt + ONE;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int PRE_W  = 6,
  parameter int SEG_W  = 4,
  parameter int SJW_W  = 3,
  parameter int MIN_TQ = 8,
  parameter int MAX_TQ = 25
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] prescale,
  input  logic [SEG_W-1:0] prop_len,
  input  logic [SEG_W-1:0] ph1_len,
  input  logic [SEG_W-1:0] ph2_len,
  input  logic [SJW_W-1:0] sjw,
  input  logic             bus_idle,
  input  logic             rx,
  output logic             tx_pulse,
  output logic             sample_pulse,
  output logic             bit_end,
  output logic             cfg_bad
);
  logic bad_c;
  logic tq_tick;
  logic fall;
  logic restart;

  cbt_cfg_check #(
    .SEG_W(SEG_W), .SJW_W(SJW_W), .MIN_TQ(MIN_TQ), .MAX_TQ(MAX_TQ)
  ) u_cfg (
    .prop_len(prop_len), .ph1_len(ph1_len), .ph2_len(ph2_len),
    .sjw(sjw), .bad(bad_c)
  );

  cbt_quantum_div #(.PRE_W(PRE_W)) u_div (
    .clk(clk), .rst(rst), .hold(bad_c), .restart(restart),
    .prescale(prescale), .tq_tick(tq_tick)
  );

  cbt_edge_det u_edge (
    .clk(clk), .rst(rst), .rx(rx), .fall(fall)
  );

  cbt_seg_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W)) u_seq (
    .clk(clk), .rst(rst), .hold(bad_c), .tq_tick(tq_tick), .fall(fall),
    .bus_idle(bus_idle), .prop_len(prop_len), .ph1_len(ph1_len),
    .ph2_len(ph2_len), .sjw(sjw), .restart(restart),
    .tx_pulse(tx_pulse), .sample_pulse(sample_pulse), .bit_end(bit_end)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_bad <= 1'b0;
    else     cfg_bad <= bad_c;
  end
endmodule

// File: rtl/cbt_checks.sv
module cbt_checks (
  input logic clk,
  input logic rst,
  input logic tx_pulse,
  input logic sample_pulse,
  input logic bit_end,
  input logic cfg_bad
);
  AST_SAMPLE_NOT_TX: assert property (@(posedge clk) disable iff (rst)
    !(sample_pulse && tx_pulse)); // R2

  AST_BITEND_NEEDS_TX: assert property (@(posedge clk) disable iff (rst)
    bit_end |-> tx_pulse); // R3

  AST_SAMPLE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
    sample_pulse |=> !sample_pulse); // R3

  AST_BAD_SILENT: assert property (@(posedge clk) disable iff (rst)
    cfg_bad |-> (!tx_pulse && !sample_pulse && !bit_end)); // R5

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!tx_pulse && !sample_pulse && !bit_end && !cfg_bad)); // R10
endmodule

bind can_bit_timer cbt_checks i_cbt_checks (
  .clk(clk), .rst(rst), .tx_pulse(tx_pulse), .sample_pulse(sample_pulse),
  .bit_end(bit_end), .cfg_bad(cfg_bad)
);

// File: tb/test_can_bit_timer.sv
module test_can_bit_timer;
  localparam int PRE_W = 6;
  localparam int SEG_W = 4;
  localparam int SJW_W = 3;
  localparam int NV    = 10;
  // prescale, prop, ph1, ph2, sjw, expect_bad, period_clk, sample_off_clk
  localparam int VEC [NV][8] = '{
    '{1, 2, 3, 3, 2, 0,  36,  24},
    '{0, 1, 2, 4, 1, 0,  16,   8},
    '{2, 8, 8, 8, 4, 0, 150, 102},
    '{3, 4, 5, 3, 3, 0, 104,  80},
    '{0, 8, 8, 9, 4, 1,   0,   0},
    '{0, 1, 2, 3, 1, 1,   0,   0},
    '{0, 3, 3, 4, 5, 1,   0,   0},
    '{0, 3, 4, 1, 1, 1,   0,   0},
    '{0, 0, 4, 4, 1, 1,   0,   0},
    '{0, 3, 3, 3, 0, 1,   0,   0}
  };

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [PRE_W-1:0] prescale = '0;
  logic [SEG_W-1:0] prop_len = 4'd2;
  logic [SEG_W-1:0] ph1_len = 4'd3;
  logic [SEG_W-1:0] ph2_len = 4'd3;
  logic [SJW_W-1:0] sjw = 3'd2;
  logic             bus_idle = 1'b1;
  logic             rx = 1'b1;
  logic             tx_pulse, sample_pulse, bit_end, cfg_bad;

  int n_chk  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  can_bit_timer #(.PRE_W(PRE_W), .SEG_W(SEG_W), .SJW_W(SJW_W)) i_can_bit_timer (
    .clk(clk), .rst(rst), .prescale(prescale), .prop_len(prop_len),
    .ph1_len(ph1_len), .ph2_len(ph2_len), .sjw(sjw), .bus_idle(bus_idle),
    .rx(rx), .tx_pulse(tx_pulse), .sample_pulse(sample_pulse),
    .bit_end(bit_end), .cfg_bad(cfg_bad)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply_cfg(input int p, input int a, input int b, input int c, input int j);
    @(negedge clk);
    rst      = 1'b1;
    prescale = PRE_W'(p);
    prop_len = SEG_W'(a);
    ph1_len  = SEG_W'(b);
    ph2_len  = SEG_W'(c);
    sjw      = SJW_W'(j);
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_tx();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (tx_pulse) break;
    end
  endtask

  // From a bit-start strobe, count clocks to the sample and next bit-start.
  // Edges: rx low at k1, high at k2, low at k3 (negative = unused).
  task automatic measure(input int k1, input int k2, input int k3,
                         output int soff, output int per, output int be);
    soff = -1; per = -1; be = -1;
    wait_tx();
    for (int i = 0; i < 400; i++) begin
      if (i > 0) @(negedge clk);
      if (i == k1) rx = 1'b0;
      if (i == k2) rx = 1'b1;
      if (i == k3) rx = 1'b0;
      if (i > 0 && sample_pulse && soff < 0) soff = i;
      if (i > 0 && tx_pulse) begin
        per = i;
        be  = int'(bit_end);
        break;
      end
    end
    rx = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int soff, per, be, cnt;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk("R10 tx", int'(tx_pulse), 0);
    chk("R10 sample", int'(sample_pulse), 0);
    chk("R10 bit_end", int'(bit_end), 0);
    chk("R10 cfg_bad", int'(cfg_bad), 0);

    // Table walk: R1 period, R2 sample offset, R3 bit_end, R4 flag, R5 silence
    for (int v = 0; v < NV; v++) begin
      apply_cfg(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4]);
      repeat (2) @(negedge clk);
      chk("R4 cfg_bad", int'(cfg_bad), VEC[v][5]);
      if (VEC[v][5] == 0) begin
        measure(-1, -1, -1, soff, per, be);
        chk("R2 sample offset", soff, VEC[v][7]);
        chk("R1 bit period", per, VEC[v][6]);
        chk("R3 bit_end with tx", be, 1);
      end else begin
        cnt = 0;
        for (int i = 0; i < 300; i++) begin
          @(negedge clk);
          if (tx_pulse || sample_pulse || bit_end) cnt++;
        end
        chk("R5 strobes while bad", cnt, 0);
      end
    end

    // R6 hard synchronization
    apply_cfg(1, 2, 3, 3, 2);
    bus_idle = 1'b1;
    wait_tx();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (sample_pulse) break;
    end
    repeat (2) @(negedge clk);
    rx = 1'b0;
    cnt = 0;
    for (int i = 1; i < 100; i++) begin
      @(negedge clk);
      if (tx_pulse) begin
        cnt = i;
        break;
      end
    end
    chk("R6 hard sync delay", cnt, 2);
    chk("R6 no bit_end", int'(bit_end), 0);
    cnt = 0;
    for (int i = 1; i < 100; i++) begin
      @(negedge clk);
      if (sample_pulse) begin
        cnt = i;
        break;
      end
    end
    chk("R6 sample after hard sync", cnt, 24);
    rx = 1'b1;

    // Resynchronization, prescale 1 (4 clk per quantum), 2/3/3, sjw 2
    bus_idle = 1'b0;
    measure(4, -1, -1, soff, per, be);
    chk("R7 lengthen by 1 sample", soff, 28);
    chk("R7 lengthen by 1 period", per, 40);
    measure(16, -1, -1, soff, per, be);
    chk("R7 clamp to sjw sample", soff, 32);
    chk("R7 clamp to sjw period", per, 44);
    measure(4, 8, 16, soff, per, be);
    chk("R9 second edge ignored sample", soff, 28);
    chk("R9 second edge ignored period", per, 40);
    measure(24, -1, -1, soff, per, be);
    chk("R8 shorten by sjw sample", soff, 24);
    chk("R8 shorten by sjw period", per, 28);
    measure(28, -1, -1, soff, per, be);
    chk("R8 shorten by remainder period", per, 32);
    measure(0, -1, -1, soff, per, be);
    chk("R9 sync segment edge sample", soff, 24);
    chk("R9 sync segment edge period", per, 36);
    measure(22, -1, -1, soff, per, be);
    chk("R11 edge on phase1 tick sample", soff, 32);
    chk("R11 edge on phase1 tick period", per, 44);
    measure(-1, -1, -1, soff, per, be);
    chk("R1 nominal after resync", per, 36);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule